// File: doc/BRIEF.md
# Halt State Wake Controller

This block tracks whether a processor core is executing or parked in a low-power halt state. When the pipeline retires a halt instruction it pulses a halt strobe and supplies the address of the next instruction. The controller then drops into the halt state and raises a low-power indication. While halted it monitors five wake sources: maskable interrupt, non-maskable interrupt, system-management interrupt, INIT and RESET.

When a qualified source appears, the controller issues a one-cycle resume strobe with a cause code and returns to the running state on the same edge. A maskable interrupt only counts as a wake when both the interrupt-enable flag and the global interrupt flag are set. When several sources are pending together, only the most urgent one is reported. For interrupt-class wakes the controller presents the saved address of the instruction after the halt. For INIT and RESET it presents no return address, because the init or reset sequencing takes over from there.

Top module: `halt_wake_ctrl`

## Requirements
- R1: When `halt_req` is 1 while the core is running, `halted_o` is 1 from the next clock edge, and the `next_pc` presented with the strobe is held as the return address.
- R2: While halted, an NMI, SMI, INIT or RESET request sampled at a clock edge makes `halted_o` 0 and `resume_o` 1 right after that edge.
- R3: While halted, a maskable interrupt wakes the core only when `if_flag` and `gif_flag` are both 1. Otherwise it is ignored and the core stays halted.
- R4: When several wake sources are pending, the cause reported is the most urgent one, in the order RESET, then INIT, then SMI, then NMI, then the maskable interrupt. `resume_cause_o` uses the codes 0 none, 1 maskable interrupt, 2 NMI, 3 SMI, 4 INIT and 5 RESET, and reads 0 whenever `resume_o` is 0.
- R5: On a resume caused by the maskable interrupt, NMI or SMI, `ret_addr_o` equals the address held at halt entry and `ret_addr_valid_o` is 1. Both keep their values until the next resume.
- R6: On a resume caused by INIT or RESET, `ret_addr_valid_o` is 0 and `ret_addr_o` is 0.
- R7: `resume_o` is 1 for exactly one cycle per wake.
- R8: A wake request that is already pending when the halt strobe is taken causes a resume after exactly one halted cycle.
- R9: A halt strobe issued in the cycle of an SMI resume is accepted, and the core is halted again from the next edge.
- R10: While running, wake requests produce no resume. While halted, `halt_req` has no effect and does not replace the held return address.
- R11: After reset, `halted_o`, `resume_o`, `resume_cause_o`, `ret_addr_o` and `ret_addr_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Halt instruction retired (one-cycle strobe) |
| next_pc | input | ADDR_W | Address of the instruction after the halt |
| if_flag | input | 1 | Interrupt-enable flag |
| gif_flag | input | 1 | Global interrupt flag |
| wake_intr | input | 1 | Maskable interrupt request |
| wake_nmi | input | 1 | Non-maskable interrupt request |
| wake_smi | input | 1 | System-management interrupt request |
| wake_init | input | 1 | INIT request |
| wake_reset | input | 1 | RESET request |
| halted_o | output | 1 | Core is halted (low-power indication) |
| resume_o | output | 1 | One-cycle resume strobe |
| resume_cause_o | output | 3 | Cause code of the resume |
| ret_addr_o | output | ADDR_W | Saved return address |
| ret_addr_valid_o | output | 1 | Return address is meaningful |

## Verification
The hardest cases to reach from the ports are a wake source that is already pending on the edge where the halt is taken, and a halt strobe that arrives in the very cycle of a resume. The directed tasks reach the first case by raising the wake lines before or together with the halt strobe. They reach the second by asserting the strobe right after the SMI resume appears. A masked maskable interrupt is held for several halted cycles, with each flag cleared in turn, before an NMI ends the halt. This shows that the masked request neither woke the core nor disturbed the saved address.

// File: rtl/halt_wake_pkg.sv
// Shared types for the halt wake controller.
// Assumes: wake sources are numbered from least to most urgent.
package halt_wake_pkg;

    localparam int NUM_SRC = 5;
    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_INTR  = 3'd1,
        CAUSE_NMI   = 3'd2,
        CAUSE_SMI   = 3'd3,
        CAUSE_INIT  = 3'd4,
        CAUSE_RESET = 3'd5
    } wake_cause_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } core_state_e;

    // Interrupt-class wakes return to the instruction after the halt.
    function automatic logic cause_saves_addr(wake_cause_e c);
        return (c == CAUSE_INTR) || (c == CAUSE_NMI) || (c == CAUSE_SMI);
    endfunction

endpackage

// File: rtl/wake_arbiter.sv
// Qualifies the wake request lines and selects the most urgent one.
// Assumes: req_vec[i] maps to cause code i+1, and a higher index is more urgent.
// Index 0 is the maskable interrupt, which is gated by both interrupt flags.
module wake_arbiter
    import halt_wake_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] req_vec,
    input  logic         if_flag,
    input  logic         gif_flag,
    output wake_cause_e  cause,
    output logic         any_wake
);

    logic [N-1:0] qual_vec;

    // Mask the maskable interrupt, then let the highest qualified index win.
    always_comb begin
        qual_vec    = req_vec;
        qual_vec[0] = req_vec[0] & if_flag & gif_flag;
        cause       = CAUSE_NONE;
        for (int i = 0; i < N; i++) begin
            if (qual_vec[i]) begin
                cause = wake_cause_e'(CAUSE_W'(i + 1));
            end
        end
        any_wake = |qual_vec;
    end

endmodule

// File: rtl/halt_fsm.sv
// Two-state run/halt sequencer that produces the one-cycle resume strobe.
// Assumes: wake_any and wake_cause come from the arbiter in the same cycle.
module halt_fsm
    import halt_wake_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        halt_req,
    input  logic        wake_any,
    input  wake_cause_e wake_cause,
    output logic        halted,
    output logic        enter_halt,
    output logic        wake_fire,
    output logic        resume,
    output wake_cause_e resume_cause
);

    core_state_e state;

    // Decode the events that happen on the coming edge.
    always_comb begin
        halted     = (state == ST_HALT);
        enter_halt = (state == ST_RUN) && halt_req;
        wake_fire  = (state == ST_HALT) && wake_any;
    end

    // Update the state and register the strobe and cause for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_RUN;
            resume       <= 1'b0;
            resume_cause <= CAUSE_NONE;
        end else begin
            resume       <= 1'b0;
            resume_cause <= CAUSE_NONE;
            if (enter_halt) begin
                state <= ST_HALT;
            end else if (wake_fire) begin
                state        <= ST_RUN;
                resume       <= 1'b1;
                resume_cause <= wake_cause;
            end
        end
    end

endmodule

// File: rtl/resume_capture.sv
// Holds the post-halt address and publishes it on an interrupt-class resume.
// Assumes: enter and fire are never both 1 in the same cycle.
module resume_capture
    import halt_wake_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic              fire,
    input  wake_cause_e       cause,
    output logic [ADDR_W-1:0] ret_addr,
    output logic              ret_valid
);

    logic [ADDR_W-1:0] held_pc;

    // Capture the address on halt entry and publish it when the core resumes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_pc   <= '0;
            ret_addr  <= '0;
            ret_valid <= 1'b0;
        end else begin
            if (enter) begin
                held_pc <= next_pc;
            end
            if (fire) begin
                if (cause_saves_addr(cause)) begin
                    ret_addr  <= held_pc;
                    ret_valid <= 1'b1;
                end else begin
                    ret_addr  <= '0;
                    ret_valid <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/halt_wake_ctrl.sv
// Top of the halt wake controller: arbiter, sequencer and address capture.
// Assumes: halt_req is a strobe from retirement, and wake lines are level requests.
module halt_wake_ctrl
    import halt_wake_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic              if_flag,
    input  logic              gif_flag,
    input  logic              wake_intr,
    input  logic              wake_nmi,
    input  logic              wake_smi,
    input  logic              wake_init,
    input  logic              wake_reset,
    output logic              halted_o,
    output logic              resume_o,
    output logic [2:0]        resume_cause_o,
    output logic [ADDR_W-1:0] ret_addr_o,
    output logic              ret_addr_valid_o
);

    logic [NUM_SRC-1:0] req_vec;
    wake_cause_e        arb_cause;
    wake_cause_e        res_cause;
    logic               arb_any;
    logic               enter_halt;
    logic               wake_fire;

    // Order the request lines from least to most urgent.
    always_comb begin
        req_vec = {wake_reset, wake_init, wake_smi, wake_nmi, wake_intr};
    end

    wake_arbiter #(.N(NUM_SRC)) u_arb (
        .req_vec  (req_vec),
        .if_flag  (if_flag),
        .gif_flag (gif_flag),
        .cause    (arb_cause),
        .any_wake (arb_any)
    );

    halt_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_req     (halt_req),
        .wake_any     (arb_any),
        .wake_cause   (arb_cause),
        .halted       (halted_o),
        .enter_halt   (enter_halt),
        .wake_fire    (wake_fire),
        .resume       (resume_o),
        .resume_cause (res_cause)
    );

    resume_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter     (enter_halt),
        .next_pc   (next_pc),
        .fire      (wake_fire),
        .cause     (arb_cause),
        .ret_addr  (ret_addr_o),
        .ret_valid (ret_addr_valid_o)
    );

    // Present the cause as a plain vector at the port.
    always_comb begin
        resume_cause_o = res_cause;
    end

endmodule

// File: rtl/halt_wake_checker.sv
// Protocol properties of the halt wake controller, bound to the top module.
// Assumes: port names match the top module so the bind can connect by name.
module halt_wake_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_req,
    input logic       if_flag,
    input logic       gif_flag,
    input logic       wake_intr,
    input logic       wake_nmi,
    input logic       wake_smi,
    input logic       wake_init,
    input logic       wake_reset,
    input logic       halted_o,
    input logic       resume_o,
    input logic [2:0] resume_cause_o,
    input logic       ret_addr_valid_o
);

    logic hard_wake;
    logic intr_ok;

    // Group the wake sources that need no flag.
    always_comb begin
        hard_wake = wake_nmi | wake_smi | wake_init | wake_reset;
        intr_ok   = wake_intr & if_flag & gif_flag;
    end

    assert_enter_halt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && halt_req) |=> halted_o);

    assert_hard_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && hard_wake) |=> (resume_o && !halted_o));

    assert_masked_intr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !hard_wake && !intr_ok) |=> (halted_o && !resume_o));

    assert_reset_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && wake_reset) |=> (resume_cause_o == 3'd5));

    assert_idle_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !resume_o |-> (resume_cause_o == 3'd0));

    assert_save_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_o && (resume_cause_o >= 3'd1) && (resume_cause_o <= 3'd3)) |-> ret_addr_valid_o);

    assert_no_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_o && (resume_cause_o >= 3'd4)) |-> !ret_addr_valid_o);

    assert_one_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |=> !resume_o);

    assert_run_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !halted_o |=> !resume_o);

endmodule

bind halt_wake_ctrl halt_wake_checker u_chk (.*);

// File: tb/tb_halt_wake_ctrl.sv
// Directed bench for the halt wake controller; one task per scenario.
module tb_halt_wake_ctrl;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt_req = 1'b0;
    logic [AW-1:0] next_pc = '0;
    logic          if_flag = 1'b0;
    logic          gif_flag = 1'b0;
    logic          wake_intr = 1'b0;
    logic          wake_nmi = 1'b0;
    logic          wake_smi = 1'b0;
    logic          wake_init = 1'b0;
    logic          wake_reset = 1'b0;
    logic          halted_o;
    logic          resume_o;
    logic [2:0]    resume_cause_o;
    logic [AW-1:0] ret_addr_o;
    logic          ret_addr_valid_o;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    halt_wake_ctrl #(.ADDR_W(AW)) dut (.*);

    // Advance one edge; inputs change and outputs are read 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_wakes();
        wake_intr = 0; wake_nmi = 0; wake_smi = 0; wake_init = 0; wake_reset = 0;
    endtask

    task automatic do_halt(logic [AW-1:0] pc);
        halt_req = 1; next_pc = pc;
        tick();
        halt_req = 0; next_pc = '0;
        check("R1 halted after strobe", halted_o, 1);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        check("R11 halted", halted_o, 0);
        check("R11 resume", resume_o, 0);
        check("R11 cause", resume_cause_o, 0);
        check("R11 addr", ret_addr_o, 0);
        check("R11 valid", ret_addr_valid_o, 0);
    endtask

    task automatic t_intr_wake();
        if_flag = 1; gif_flag = 1;
        do_halt(32'h0000_1004);
        tick();
        check("R1 still halted", halted_o, 1);
        wake_intr = 1;
        tick();
        clear_wakes();
        check("R3 intr resume", resume_o, 1);
        check("R2 not halted", halted_o, 0);
        check("R4 intr cause", resume_cause_o, 1);
        check("R5 intr addr", ret_addr_o, 32'h0000_1004);
        check("R5 intr valid", ret_addr_valid_o, 1);
        tick();
        check("R7 pulse ends", resume_o, 0);
        check("R4 cause idle", resume_cause_o, 0);
        check("R5 addr held", ret_addr_o, 32'h0000_1004);
    endtask

    task automatic t_intr_masked();
        if_flag = 0; gif_flag = 1;
        do_halt(32'h0000_2008);
        wake_intr = 1;
        repeat (3) tick();
        check("R3 if=0 stays halted", halted_o, 1);
        check("R3 if=0 no resume", resume_o, 0);
        if_flag = 1; gif_flag = 0;
        repeat (3) tick();
        check("R3 gif=0 stays halted", halted_o, 1);
        check("R3 gif=0 no resume", resume_o, 0);
        wake_nmi = 1;
        tick();
        clear_wakes();
        check("R2 nmi resume", resume_o, 1);
        check("R4 nmi beats intr", resume_cause_o, 2);
        check("R5 nmi addr", ret_addr_o, 32'h0000_2008);
        gif_flag = 1;
        tick();
    endtask

    task automatic t_priority();
        wake_reset = 1; wake_init = 1; wake_smi = 1; wake_nmi = 1; wake_intr = 1;
        do_halt(32'h0000_3000);
        tick();
        clear_wakes();
        check("R4 reset wins", resume_cause_o, 5);
        check("R6 reset no valid", ret_addr_valid_o, 0);
        check("R6 reset addr zero", ret_addr_o, 0);
        tick();
        wake_init = 1; wake_smi = 1; wake_nmi = 1;
        do_halt(32'h0000_3010);
        tick();
        clear_wakes();
        check("R4 init wins", resume_cause_o, 4);
        check("R6 init no valid", ret_addr_valid_o, 0);
        tick();
        wake_smi = 1; wake_nmi = 1; wake_intr = 1;
        do_halt(32'h0000_3020);
        tick();
        clear_wakes();
        check("R4 smi wins", resume_cause_o, 3);
        check("R5 smi addr", ret_addr_o, 32'h0000_3020);
        tick();
    endtask

    task automatic t_pending();
        wake_nmi = 1;
        do_halt(32'h0000_4000);
        check("R8 no resume while halted", resume_o, 0);
        tick();
        clear_wakes();
        check("R8 resume after one cycle", resume_o, 1);
        check("R8 left halt", halted_o, 0);
        check("R8 cause", resume_cause_o, 2);
        tick();
    endtask

    task automatic t_smi_rehalt();
        do_halt(32'h0000_5000);
        wake_smi = 1;
        tick();
        wake_smi = 0;
        check("R9 smi resume", resume_o, 1);
        halt_req = 1; next_pc = 32'h0000_5000;
        tick();
        halt_req = 0;
        check("R9 re-halted", halted_o, 1);
        check("R7 strobe gone", resume_o, 0);
        wake_nmi = 1;
        tick();
        clear_wakes();
        check("R9 second wake addr", ret_addr_o, 32'h0000_5000);
        tick();
    endtask

    task automatic t_ignored();
        wake_nmi = 1; wake_smi = 1;
        repeat (3) tick();
        check("R10 run no resume", resume_o, 0);
        check("R10 run not halted", halted_o, 0);
        clear_wakes();
        do_halt(32'h0000_6000);
        halt_req = 1; next_pc = 32'h0000_6abc;
        tick();
        halt_req = 0;
        check("R10 halt during halt", halted_o, 1);
        wake_nmi = 1;
        tick();
        clear_wakes();
        check("R10 addr not replaced", ret_addr_o, 32'h0000_6000);
        tick();
    endtask

    initial begin
        t_reset();
        t_intr_wake();
        t_intr_masked();
        t_priority();
        t_pending();
        t_smi_rehalt();
        t_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule